// File: doc/BRIEF.md
# Mode-Banked Register File

This block is the general register storage for a 32-bit core that switches between a user view and several privileged exception views. Software always sees sixteen logical registers, numbered 0 to 15. Behind them sit 31 physical 32-bit registers. The current processor mode decides which physical copy answers to each logical number. Each privileged exception mode therefore gets its own stack pointer (logical 13) and return-link register (logical 14). The fast-interrupt mode gets a wider private set from logical 7 upward, so its handler can start work without saving anything. Logical 15 is the program counter, which the fetch unit owns. Reads of it return the externally supplied PC, and writes to it through this block do nothing.

There are two combinational read ports and one write port, which commits on the clock edge. A separate port reads and writes the saved-status word belonging to the current mode. The five exception modes each own one such word. The user-level modes have none, so that port reads zero there and drops writes. Reads show the contents as they stood before the current edge, so a register written in a cycle reads its old value in that same cycle.

Top module: `bankreg_file`

## Requirements
- R1: After reset is released, every logical register 0 to 14 in every mode reads 0, and the saved-status port reads 0 in every mode.
- R2: `mode` is encoded 0=user, 1=fast interrupt, 2=interrupt, 3=supervisor, 4=abort, 5=undefined, 7=system. Code 6 is reserved and behaves as user. User, system and the reserved code all see one shared register set.
- R3: Modes 2, 3, 4 and 5 each hold private copies of logical registers 13 and 14. A write to one of these in one mode is not visible in any other mode.
- R4: Mode 1 holds private copies of logical registers 7 through 14. These copies are isolated from every other mode.
- R5: Logical registers 0 to 6 are one shared set in all modes. Logical registers 7 to 12 are one shared set in every mode except mode 1.
- R6: A read of logical register 15 on either read port returns `pc_in` in the same cycle.
- R7: A write to logical register 15 through the write port changes no register in any mode.
- R8: Each of modes 1 to 5 owns one saved-status word. A write on the status port in such a mode is returned by status reads in that mode from the next cycle on, and no other mode's word changes.
- R9: In modes 0, 6 and 7 the status port reads 0, and a write on it changes no saved-status word.
- R10: A write commits on the rising clock edge. A read in the write cycle returns the old value, and a read from the next cycle on returns the new value.
- R11: The two read ports are independent: each returns the register its own index selects, under the same mode mapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| mode | input | 3 | Current processor mode code |
| pc_in | input | 32 | Program counter value returned for logical register 15 |
| rd_a_idx | input | 4 | Logical index for read port A |
| rd_a_data | output | 32 | Read port A data |
| rd_b_idx | input | 4 | Logical index for read port B |
| rd_b_data | output | 32 | Read port B data |
| wr_en | input | 1 | Write enable for the general write port |
| wr_idx | input | 4 | Logical index for the write |
| wr_data | input | 32 | Write data |
| psr_wr_en | input | 1 | Write enable for the current mode's saved-status word |
| psr_wr_data | input | 32 | Saved-status write data |
| psr_rd_data | output | 32 | Current mode's saved-status word, 0 in user-level modes |

## Verification
The hardest situation to reach from the ports is aliasing between banks. A bad mapping could send two modes to the same physical copy, and that only shows when one mode writes and a different mode reads back. The stimulus writes a value that encodes the mode, the index and the pass into every logical register in every mode. It does this twice, with the mode order reversed on the second pass. It then reads every register in every mode on both ports and compares against a bench-side ownership table. Any copy shared by mistake then holds the wrong writer's tag.

// File: rtl/bankreg_pkg.sv
package bankreg_pkg;

  typedef enum logic [2:0] {
    MD_USR = 3'd0,
    MD_FIQ = 3'd1,
    MD_IRQ = 3'd2,
    MD_SVC = 3'd3,
    MD_ABT = 3'd4,
    MD_UND = 3'd5,
    MD_RSV = 3'd6,
    MD_SYS = 3'd7
  } mode_e;

  localparam int NUM_LOGICAL  = 16;
  localparam int PC_IDX       = 15;
  localparam int FIQ_FIRST    = 7;
  localparam int SP_IDX       = 13;
  localparam int LR_IDX       = 14;
  localparam int COMMON_COUNT = 15;
  localparam int FIQ_COUNT    = LR_IDX - FIQ_FIRST + 1;
  localparam int EXC_MODES    = 4;
  localparam int N_PHYS       = COMMON_COUNT + FIQ_COUNT + 2 * EXC_MODES;
  localparam int N_SPSR       = EXC_MODES + 1;
  localparam int PHYS_W       = $clog2(N_PHYS);
  localparam int SPSR_W       = $clog2(N_SPSR);

  // Logical-to-physical index translation for a given mode.
  function automatic logic [PHYS_W-1:0] phys_of(input mode_e m, input logic [3:0] idx);
    int i;
    int r;
    i = int'(idx);
    r = i;
    if (m == MD_FIQ && i >= FIQ_FIRST && i <= LR_IDX)
      r = COMMON_COUNT + (i - FIQ_FIRST);
    else if ((i == SP_IDX || i == LR_IDX) &&
             (m == MD_IRQ || m == MD_SVC || m == MD_ABT || m == MD_UND))
      r = COMMON_COUNT + FIQ_COUNT + 2 * (int'(m) - int'(MD_IRQ)) + (i - SP_IDX);
    return PHYS_W'(r);
  endfunction

  function automatic logic has_spsr(input mode_e m);
    return (m == MD_FIQ || m == MD_IRQ || m == MD_SVC || m == MD_ABT || m == MD_UND);
  endfunction

  function automatic logic [SPSR_W-1:0] spsr_slot(input mode_e m);
    int s;
    s = has_spsr(m) ? int'(m) - int'(MD_FIQ) : 0;
    return SPSR_W'(s);
  endfunction

endpackage

// File: rtl/bankreg_map.sv
module bankreg_map
  import bankreg_pkg::*;
(
  input  logic [2:0]        mode,
  input  logic [3:0]        idx,
  output logic [PHYS_W-1:0] phys,
  output logic              is_pc
);
  mode_e m;
  always_comb begin
    m     = mode_e'(mode);
    phys  = phys_of(m, idx);
    is_pc = (int'(idx) == PC_IDX);
  end
endmodule

// File: rtl/bankreg_store.sv
module bankreg_store
  import bankreg_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DEPTH  = N_PHYS
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     we,
  input  logic [PHYS_W-1:0]        waddr,
  input  logic [DATA_W-1:0]        wdata,
  input  logic [PHYS_W-1:0]        raddr_a,
  input  logic [PHYS_W-1:0]        raddr_b,
  output logic [DATA_W-1:0]        rdata_a,
  output logic [DATA_W-1:0]        rdata_b,
  output logic [DEPTH-1:0]         we_vec
);
  logic [DATA_W-1:0] regs [DEPTH];

  genvar g;
  generate
    for (g = 0; g < DEPTH; g++) begin : g_reg
      assign we_vec[g] = we && (int'(waddr) == g);
      always_ff @(posedge clk) begin
        if (!rst_n)        regs[g] <= '0;
        else if (we_vec[g]) regs[g] <= wdata;
      end
    end
  endgenerate

  always_comb begin
    rdata_a = (int'(raddr_a) < DEPTH) ? regs[raddr_a] : '0;
    rdata_b = (int'(raddr_b) < DEPTH) ? regs[raddr_b] : '0;
  end
endmodule

// File: rtl/bankreg_spsr.sv
module bankreg_spsr
  import bankreg_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int SLOTS  = N_SPSR
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              valid,
  input  logic [SPSR_W-1:0] slot,
  input  logic              we,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic [SLOTS-1:0]  we_vec
);
  logic [DATA_W-1:0] words [SLOTS];

  genvar g;
  generate
    for (g = 0; g < SLOTS; g++) begin : g_word
      assign we_vec[g] = we && valid && (int'(slot) == g);
      always_ff @(posedge clk) begin
        if (!rst_n)         words[g] <= '0;
        else if (we_vec[g]) words[g] <= wdata;
      end
    end
  endgenerate

  always_comb begin
    rdata = (valid && int'(slot) < SLOTS) ? words[slot] : '0;
  end
endmodule

// File: rtl/bankreg_file.sv
module bankreg_file
  import bankreg_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        mode,
  input  logic [DATA_W-1:0] pc_in,
  input  logic [3:0]        rd_a_idx,
  output logic [DATA_W-1:0] rd_a_data,
  input  logic [3:0]        rd_b_idx,
  output logic [DATA_W-1:0] rd_b_data,
  input  logic              wr_en,
  input  logic [3:0]        wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              psr_wr_en,
  input  logic [DATA_W-1:0] psr_wr_data,
  output logic [DATA_W-1:0] psr_rd_data
);
  localparam int NPORT = 3;  // read A, read B, write

  logic [3:0]        idx_arr  [NPORT];
  logic [PHYS_W-1:0] phys_arr [NPORT];
  logic              pc_arr   [NPORT];

  assign idx_arr[0] = rd_a_idx;
  assign idx_arr[1] = rd_b_idx;
  assign idx_arr[2] = wr_idx;

  genvar p;
  generate
    for (p = 0; p < NPORT; p++) begin : g_map
      bankreg_map u_map (
        .mode  (mode),
        .idx   (idx_arr[p]),
        .phys  (phys_arr[p]),
        .is_pc (pc_arr[p])
      );
    end
  endgenerate

  // Named events for the checker.
  logic                gpr_we;
  logic [N_PHYS-1:0]   gpr_we_vec;
  logic [N_SPSR-1:0]   spsr_we_vec;
  logic                spsr_valid;
  logic [SPSR_W-1:0]   spsr_idx;
  logic [DATA_W-1:0]   store_a;
  logic [DATA_W-1:0]   store_b;

  assign gpr_we     = wr_en && !pc_arr[2];
  assign spsr_valid = has_spsr(mode_e'(mode));
  assign spsr_idx   = spsr_slot(mode_e'(mode));

  bankreg_store #(.DATA_W(DATA_W), .DEPTH(N_PHYS)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (gpr_we),
    .waddr   (phys_arr[2]),
    .wdata   (wr_data),
    .raddr_a (phys_arr[0]),
    .raddr_b (phys_arr[1]),
    .rdata_a (store_a),
    .rdata_b (store_b),
    .we_vec  (gpr_we_vec)
  );

  bankreg_spsr #(.DATA_W(DATA_W), .SLOTS(N_SPSR)) u_spsr (
    .clk    (clk),
    .rst_n  (rst_n),
    .valid  (spsr_valid),
    .slot   (spsr_idx),
    .we     (psr_wr_en),
    .wdata  (psr_wr_data),
    .rdata  (psr_rd_data),
    .we_vec (spsr_we_vec)
  );

  assign rd_a_data = pc_arr[0] ? pc_in : store_a;
  assign rd_b_data = pc_arr[1] ? pc_in : store_b;
endmodule

// File: rtl/bankreg_chk.sv
module bankreg_chk
  import bankreg_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic [2:0]        mode,
  input logic [DATA_W-1:0] pc_in,
  input logic [3:0]        rd_a_idx,
  input logic [DATA_W-1:0] rd_a_data,
  input logic [3:0]        rd_b_idx,
  input logic [DATA_W-1:0] rd_b_data,
  input logic              wr_en,
  input logic [3:0]        wr_idx,
  input logic [DATA_W-1:0] wr_data,
  input logic              psr_wr_en,
  input logic [DATA_W-1:0] psr_wr_data,
  input logic [DATA_W-1:0] psr_rd_data,
  input logic [N_PHYS-1:0] gpr_we_vec,
  input logic [N_SPSR-1:0] spsr_we_vec
);
  logic priv;
  assign priv = (mode >= 3'd1) && (mode <= 3'd5);

  assert_pc_read_a_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_a_idx == 4'd15) |-> (rd_a_data == pc_in));
  assert_pc_read_b_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_b_idx == 4'd15) |-> (rd_b_data == pc_in));
  assert_pc_write_dropped_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_idx == 4'd15) |-> (gpr_we_vec == '0));
  assert_single_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gpr_we_vec) && (wr_en || gpr_we_vec == '0));
  assert_write_visible_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_idx != 4'd15) |=>
      (rd_a_idx != $past(wr_idx) || mode != $past(mode) || rd_a_data == $past(wr_data)));
  assert_spsr_user_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !priv |-> (spsr_we_vec == '0 && psr_rd_data == '0));
  assert_spsr_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (psr_wr_en && priv) |=> (mode != $past(mode) || psr_rd_data == $past(psr_wr_data)));
  assert_spsr_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(spsr_we_vec));
endmodule

bind bankreg_file bankreg_chk #(.DATA_W(DATA_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .mode        (mode),
  .pc_in       (pc_in),
  .rd_a_idx    (rd_a_idx),
  .rd_a_data   (rd_a_data),
  .rd_b_idx    (rd_b_idx),
  .rd_b_data   (rd_b_data),
  .wr_en       (wr_en),
  .wr_idx      (wr_idx),
  .wr_data     (wr_data),
  .psr_wr_en   (psr_wr_en),
  .psr_wr_data (psr_wr_data),
  .psr_rd_data (psr_rd_data),
  .gpr_we_vec  (gpr_we_vec),
  .spsr_we_vec (spsr_we_vec)
);

// File: tb/sim_bankreg_file.sv
`timescale 1ns/1ps
module sim_bankreg_file;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [2:0]  mode = 0;
  logic [31:0] pc_in = 0;
  logic [3:0]  rd_a_idx = 0, rd_b_idx = 0, wr_idx = 0;
  logic [31:0] rd_a_data, rd_b_data, wr_data = 0, psr_wr_data = 0, psr_rd_data;
  logic        wr_en = 0, psr_wr_en = 0;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  logic [31:0] shadow [8][16];
  logic [31:0] psr_shadow [8];

  always #10 clk = ~clk;

  bankreg_file u0 (
    .clk(clk), .rst_n(rst_n), .mode(mode), .pc_in(pc_in),
    .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
    .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .psr_wr_en(psr_wr_en), .psr_wr_data(psr_wr_data), .psr_rd_data(psr_rd_data)
  );

  // Which storage owns (mode, idx): 0 = shared, else the mode code.
  function automatic int owner(input int m, input int i);
    if (m == 1 && i >= 7) return 1;
    if (m >= 2 && m <= 5 && i >= 13) return m;
    return 0;
  endfunction

  function automatic string tag_of(input int m, input int i);
    if (i == 15) return "R6";
    if (i < 7) return "R5";
    if (m == 1) return "R4";
    if (i <= 12) return "R5";
    if (m >= 2 && m <= 5) return "R3";
    return "R2";
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_write(input int m, input int i, input logic [31:0] d);
    @(negedge clk);
    mode = 3'(m); wr_idx = 4'(i); wr_data = d; wr_en = 1;
    @(posedge clk); #1;
    wr_en = 0;
    if (i != 15) shadow[owner(m, i)][i] = d;
  endtask

  // Read every index in one mode on both ports; port B reads 15-i (R11).
  task automatic sweep_mode(input int m, input string force_tag);
    for (int i = 0; i < 16; i++) begin
      int j;
      string ta, tb;
      logic [31:0] ea, eb;
      j = 15 - i;
      @(negedge clk);
      mode = 3'(m); rd_a_idx = 4'(i); rd_b_idx = 4'(j);
      pc_in = 32'h0000_8000 + 32'(m * 64 + i * 4);
      #1;
      ea = (i == 15) ? pc_in : shadow[owner(m, i)][i];
      eb = (j == 15) ? pc_in : shadow[owner(m, j)][j];
      ta = (force_tag != "") ? force_tag : tag_of(m, i);
      tb = (force_tag != "") ? force_tag : tag_of(m, j);
      chk($sformatf("%s mode=%0d idx=%0d portA", ta, m, i), rd_a_data, ea);
      chk($sformatf("%s/R11 mode=%0d idx=%0d portB", tb, m, j), rd_b_data, eb);
    end
  endtask

  task automatic psr_sweep(input string force_tag);
    for (int m = 0; m < 8; m++) begin
      logic [31:0] e;
      @(negedge clk);
      mode = 3'(m); #1;
      e = (m >= 1 && m <= 5) ? psr_shadow[m] : 32'h0;
      chk($sformatf("%s mode=%0d status read", (force_tag != "") ? force_tag :
          ((m >= 1 && m <= 5) ? "R8" : "R9"), m), psr_rd_data, e);
    end
  endtask

  initial begin
    #(20 * 150000);
    failures++;
    $display("FAIL watchdog actual=running expected=finished");
    if (!done) begin
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int order [8];
    order = '{0, 1, 2, 3, 4, 5, 7, 6};
    for (int m = 0; m < 8; m++) begin
      psr_shadow[m] = 0;
      for (int i = 0; i < 16; i++) shadow[m][i] = 0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;

    // R1: reset contents
    for (int m = 0; m < 8; m++) sweep_mode(m, "R1");
    psr_sweep("R1");

    // Two passes of full writes, mode order reversed on the second (R2-R5)
    for (int p = 0; p < 2; p++) begin
      for (int k = 0; k < 8; k++) begin
        int m;
        m = (p == 0) ? order[k] : order[7 - k];
        for (int i = 0; i < 16; i++)
          do_write(m, i, 32'hA000_0000 | 32'(p << 16) | 32'(m << 8) | 32'(i));
      end
      for (int m = 0; m < 8; m++) sweep_mode(m, "");
    end

    // R7: a write to index 15 in each mode leaves all registers intact
    for (int m = 0; m < 8; m++) begin
      do_write(m, 15, 32'hDEAD_0000 | 32'(m));
      sweep_mode(m, "R7");
    end

    // R8/R9: status word per mode
    for (int m = 0; m < 8; m++) begin
      @(negedge clk);
      mode = 3'(m); psr_wr_data = 32'h5000_0000 | 32'(m * 17); psr_wr_en = 1;
      @(posedge clk); #1;
      psr_wr_en = 0;
      if (m >= 1 && m <= 5) psr_shadow[m] = 32'h5000_0000 | 32'(m * 17);
      psr_sweep("");
    end

    // R10: same-cycle read sees old value, next cycle sees new
    @(negedge clk);
    mode = 3'd3; rd_a_idx = 4'd13; wr_idx = 4'd13; wr_data = 32'h1234_5678; wr_en = 1;
    #1;
    chk("R10 same-cycle read old", rd_a_data, shadow[3][13]);
    @(posedge clk); #1;
    wr_en = 0;
    chk("R10 next-cycle read new", rd_a_data, 32'h1234_5678);
    shadow[3][13] = 32'h1234_5678;
    @(negedge clk);
    mode = 3'd2; psr_wr_data = 32'hCAFE_0002; psr_wr_en = 1;
    #1;
    chk("R10 status same-cycle old", psr_rd_data, psr_shadow[2]);
    @(posedge clk); #1;
    psr_wr_en = 0;
    chk("R10 status next-cycle new", psr_rd_data, 32'hCAFE_0002);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule